// File: doc/BRIEF.md
# Global-History Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a short shift register of the outcomes of the most recently resolved branches, in program order across all branches. The value of that register picks one of several banks of 2-bit saturating counters. Bits of the branch PC then pick one counter inside the chosen bank. The top bit of that counter is the prediction. Because the bank depends on what neighbouring branches just did, a branch whose outcome follows from an earlier one gets its own counter for each recent pattern.

The lookup port is purely combinational. A decode stage drives a PC and reads taken or not-taken in the same cycle. The training port takes the PC and the real outcome of a resolved branch. In one clock edge it moves the selected counter one step toward that outcome and shifts the outcome into the history. The counter is chosen with the history as it stood before the shift. When a lookup and a training update fall in the same cycle, the lookup sees the state from before that edge.

Top module: `gh_dir_pred`

## Requirements
- R1: After reset the history register holds 0 and every counter holds 01 (weakly not-taken), so every lookup returns not-taken until training occurs.
- R2: `pred_taken_o` is bit 1 of the counter in bank number `history` at entry `pc_i[IDX_W+1:2]`; 1 means taken.
- R3: PC bits [1:0] and the PC bits above IDX_W+1 have no effect on which counter a lookup or an update selects.
- R4: On each accepted update the history shifts left by one; the new outcome enters bit 0 (1 = taken) and the oldest bit is dropped. Without an update the history holds its value.
- R5: An update with outcome taken raises the selected counter by one and saturates at 11. An update with outcome not-taken lowers it by one and saturates at 00.
- R6: An update selects its counter with the history value from before that update's own outcome is shifted in.
- R7: A counter in a saturated state changes its predicted direction only after two consecutive opposite outcomes.
- R8: A lookup made in the same cycle as an update returns the prediction from the state before that update takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | PC_W | PC of the branch being looked up |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| upd_valid_i | input | 1 | A resolved branch is presented for training |
| upd_pc_i | input | PC_W | PC of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome, 1 = taken |

## Verification
The hardest case to reach from the ports is proving which history value an update used. Every update also changes the history, so the counter it trained usually falls under a bank that the next lookup no longer reads. Directed sequences handle this. They train one branch once, then issue not-taken updates on a different PC to walk the history back to 00. A lookup of the first branch then shows whether the pre-shift bank was trained. The same steering keeps the history fixed at 00 (repeated not-taken updates) or 11 (repeated taken updates) while one counter is driven into saturation and out again. Constrained-random traffic is concentrated on a few counter indices with random upper and lower PC bits, and runs against a reference model in the bench.

// File: rtl/gh_pred_pkg.sv
package gh_pred_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET = 2'b01;

  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    if (taken) return (cur == 2'b11) ? cur : ctr_t'(cur + 2'd1);
    else       return (cur == 2'b00) ? cur : ctr_t'(cur - 2'd1);
  endfunction
endpackage

// File: rtl/gh_hist_reg.sv
module gh_hist_reg #(
  parameter int HIST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              taken_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (shift_i) hist_q <= {hist_q[HIST_W-2:0], taken_i};
  end

  assign hist_o = hist_q;

  AST_HIST_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> hist_o[0] == $past(taken_i) &&
                hist_o[HIST_W-1:1] == $past(hist_o[HIST_W-2:0])); // R4
  AST_HIST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(hist_o)); // R4
endmodule

// File: rtl/gh_ctr_bank.sv
module gh_ctr_bank
  import gh_pred_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output ctr_t             rd_ctr_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t ctr_q [DEPTH];
  ctr_t wr_old;

  assign wr_old   = ctr_q[wr_idx_i];
  assign rd_ctr_o = ctr_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_RESET;
    end else if (wr_en_i) begin
      ctr_q[wr_idx_i] <= ctr_step(wr_old, wr_taken_i);
    end
  end

  // checker-side copy of the last written index
  logic [IDX_W-1:0] chk_idx_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_idx_q <= '0;
    else         chk_idx_q <= wr_idx_i;
  end

  AST_SAT_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_taken_i && wr_old == 2'b11 |=> ctr_q[chk_idx_q] == 2'b11); // R5
  AST_SAT_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_taken_i && wr_old == 2'b00 |=> ctr_q[chk_idx_q] == 2'b00); // R5
  AST_CTR_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_taken_i && wr_old != 2'b11 |=> ctr_q[chk_idx_q] > $past(wr_old)); // R5
  AST_CTR_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_taken_i && wr_old != 2'b00 |=> ctr_q[chk_idx_q] < $past(wr_old)); // R5
endmodule

// File: rtl/gh_dir_pred.sv
module gh_dir_pred
  import gh_pred_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 10,
  parameter int HIST_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] pc_i,
  output logic            pred_taken_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i
);
  localparam int BANKS = 1 << HIST_W;
  localparam int LSB   = 2;

  logic [HIST_W-1:0] hist;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  ctr_t              bank_rd [BANKS];

  assign rd_idx = pc_i[IDX_W+LSB-1:LSB];
  assign wr_idx = upd_pc_i[IDX_W+LSB-1:LSB];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pc_i[PC_W-1:IDX_W+LSB], pc_i[LSB-1:0],
                            upd_pc_i[PC_W-1:IDX_W+LSB], upd_pc_i[LSB-1:0]};

  gh_hist_reg #(.HIST_W(HIST_W)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(upd_valid_i),
    .taken_i(upd_taken_i),
    .hist_o (hist)
  );

  // bank chosen by pre-shift history for both read and write
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    gh_ctr_bank #(.IDX_W(IDX_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rd_idx_i  (rd_idx),
      .rd_ctr_o  (bank_rd[b]),
      .wr_en_i   (upd_valid_i && (hist == HIST_W'(b))),
      .wr_idx_i  (wr_idx),
      .wr_taken_i(upd_taken_i)
    );
  end

  ctr_t sel_ctr;
  assign sel_ctr      = bank_rd[hist];
  assign pred_taken_o = sel_ctr[1];

  AST_PRED_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(pred_taken_o)); // R2
endmodule

// File: tb/gh_dir_pred_tb.sv
module gh_dir_pred_tb;
  localparam int PC_W = 32, IDX_W = 10, HIST_W = 2;
  localparam int DEPTH = 1 << IDX_W;
  localparam int BANKS = 1 << HIST_W;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [PC_W-1:0] pc_i = '0, upd_pc_i = '0;
  logic upd_valid_i = 1'b0, upd_taken_i = 1'b0;
  logic pred_taken_o;

  always #2 clk = ~clk;

  gh_dir_pred #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pc_i(pc_i), .pred_taken_o(pred_taken_o),
    .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i), .upd_taken_i(upd_taken_i));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [1:0]        m_ctr [BANKS*DEPTH];
  logic [HIST_W-1:0] m_hist;

  function automatic int m_slot(input logic [HIST_W-1:0] h, input logic [PC_W-1:0] pc);
    return int'(h) * DEPTH + int'(pc[IDX_W+1:2]);
  endfunction

  function automatic logic m_pred(input logic [PC_W-1:0] pc);
    return m_ctr[m_slot(m_hist, pc)][1];
  endfunction

  task automatic m_reset();
    m_hist = '0;
    for (int i = 0; i < BANKS*DEPTH; i++) m_ctr[i] = 2'b01;
  endtask

  task automatic m_update(input logic [PC_W-1:0] pc, input logic t);
    int s;
    s = m_slot(m_hist, pc);
    if (t && m_ctr[s] != 2'b11) m_ctr[s] = m_ctr[s] + 2'd1;
    if (!t && m_ctr[s] != 2'b00) m_ctr[s] = m_ctr[s] - 2'd1;
    m_hist = {m_hist[HIST_W-2:0], t};
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pred=%0b expected=%0b", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check lookup before edge, then apply model
  task automatic step(input string req, input logic [PC_W-1:0] lpc,
                      input logic v, input logic [PC_W-1:0] upc, input logic t);
    @(negedge clk);
    pc_i = lpc; upd_valid_i = v; upd_pc_i = upc; upd_taken_i = t;
    #1 check(req, pred_taken_o, m_pred(lpc));
    @(posedge clk);
    #0.5;
    if (v) m_update(upc, t);
  endtask

  task automatic probe(input string req, input logic [PC_W-1:0] lpc, input logic exp);
    @(negedge clk);
    pc_i = lpc; upd_valid_i = 1'b0;
    #1 check(req, pred_taken_o, exp);
    check(req, pred_taken_o, m_pred(lpc));
  endtask

  localparam logic [PC_W-1:0] PC_A = 32'h0000_0014;  // index 5
  localparam logic [PC_W-1:0] PC_B = 32'h0000_0040;  // index 16

  initial begin
    int dummy;
    dummy = $urandom(32'h5eed_0042);
    m_reset();
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1: reset state
    probe("R1", PC_A, 1'b0);
    probe("R1", 32'hFFFF_FFFC, 1'b0);
    probe("R1", PC_B, 1'b0);

    // R6/R4: taken on A trains bank 0, history -> 01
    step("R8", PC_A, 1'b1, PC_A, 1'b1);
    probe("R6", PC_A, 1'b0);
    step("R4", PC_B, 1'b1, PC_B, 1'b0);   // hist 10
    step("R4", PC_B, 1'b1, PC_B, 1'b0);   // hist 00
    probe("R6", PC_A, 1'b1);              // bank0[A] = 10
    // R3: aliasing PCs share the counter
    probe("R3", PC_A | 32'hABC0_0003, 1'b1);
    probe("R3", PC_A | 32'h0000_1000, 1'b1);

    // R5/R7 at history 00: saturate low, then hysteresis
    repeat (4) step("R5", PC_A, 1'b1, PC_A, 1'b0);
    probe("R5", PC_A, 1'b0);
    step("R7", PC_A, 1'b1, PC_A, 1'b1);   // bank0[A] 01, hist 01
    step("R7", PC_B, 1'b1, PC_B, 1'b0);
    step("R7", PC_B, 1'b1, PC_B, 1'b0);   // hist 00
    probe("R7", PC_A, 1'b0);              // still not-taken after one
    step("R7", PC_A, 1'b1, PC_A, 1'b1);   // bank0[A] 10
    step("R7", PC_B, 1'b1, PC_B, 1'b0);
    step("R7", PC_B, 1'b1, PC_B, 1'b0);
    probe("R7", PC_A, 1'b1);              // flips after second

    // R5/R7 at history 11: saturate high
    repeat (5) step("R5", PC_A, 1'b1, PC_A, 1'b1);
    probe("R5", PC_A, 1'b1);
    // R8: same-cycle lookup of the counter being trained
    step("R8", PC_B, 1'b1, PC_B, 1'b1);

    // R2/R3: random traffic on a few indices with random outer bits
    for (int i = 0; i < 4000; i++) begin
      logic [PC_W-1:0] lp, up;
      lp = $urandom(); up = $urandom();
      if ($urandom_range(0, 3) != 0) begin
        lp[IDX_W+1:2] = IDX_W'($urandom_range(0, 7));
        up[IDX_W+1:2] = IDX_W'($urandom_range(0, 7));
      end
      step("R2", lp, $urandom_range(0, 1) == 1, up, $urandom_range(0, 1) == 1);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule